// File: doc/BRIEF.md
# Virtual Channel Admission Controller

This block hands out the output virtual channels of one service level at one output port of a packet router. Input-side virtual channels raise a header request when a packet's first flit is ready to leave toward this output. The controller picks one requester at a time with a rotating-priority arbiter. It makes a pick only when at least one output virtual channel is idle. The chosen requester receives the lowest-numbered idle output channel. That channel records the requester's index and is marked busy.

The grant stays up until the requester withdraws its header request, so each request is bound to exactly one output channel. An output channel stays busy for the whole packet. When its datapath reports that the tail flit has been handed over, the channel frees itself and its stored requester index returns to zero. Body and tail flits never pass through this block. Only the header admission and the busy bookkeeping live here.

Top module: `vc_admit_ctrl`

## Requirements
- R1: While reset is applied and immediately after release, `hdr_gnt`, `ovc_load` and `ovc_busy` are zero and every field of `ovc_src_idx` is zero.
- R2: At most one bit of `hdr_gnt` is set. Requesters are served round-robin, searching upward (with wrap-around) from the requester after the one last granted. After reset, requester 0 has first priority.
- R3: A new assignment is made only when at least one header request and at least one idle output channel exist. When every output channel is busy, pending requests receive no grant until a channel frees.
- R4: The assigned output channel is the lowest-numbered idle one. Its number appears on `gnt_ovc`, and its bit of `ovc_load` is high for exactly one cycle.
- R5: In the cycle the grant appears, the assigned channel's `ovc_busy` bit is high. Its field of `ovc_src_idx` holds the granted requester's index. Field v occupies bits [v*RW +: RW], where RW = clog2(NUM_REQ).
- R6: A grant holds while its header request stays high. The grant clears one cycle after the request is sampled low. The next assignment can occur no earlier than the cycle after that.
- R7: A `tail_done` pulse on a busy output channel clears its busy bit and zeroes its index field one cycle later. A pulse on an idle channel has no effect.
- R8: A grant, `gnt_ovc` and `ovc_load` appear one clock after the header request is first sampled high with an idle controller and an idle output channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_req | input | NUM_REQ | Header requests from input virtual channels, held until granted and served |
| tail_done | input | NUM_OVC | One-cycle pulses from output channel datapaths when a tail flit has been handed over |
| hdr_gnt | output | NUM_REQ | One-hot grant to the admitted requester |
| gnt_ovc | output | clog2(NUM_OVC) | Number of the output channel assigned to the current grant |
| ovc_load | output | NUM_OVC | One-cycle strobe to the output channel receiving a new packet |
| ovc_busy | output | NUM_OVC | Per output channel: occupied by a packet |
| ovc_src_idx | output | NUM_OVC*clog2(NUM_REQ) | Per output channel: index of the input channel feeding it |

## Verification
The hardest state to reach is a stall: requests pending while every output channel is occupied, then release of exactly one channel so the round-robin pointer and the lowest-free choice are both exercised. The bench reaches it by holding all four requests, letting two grants fill both channels, and confirming several idle cycles before a single tail pulse frees one. Freeing channels in the opposite order afterwards forces an assignment to channel 0 while channel 1 is busy. Tail pulses on idle channels are then applied to show that they leave state untouched.

// File: rtl/vca_pkg.sv
package vca_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } adm_state_e;
endpackage

// File: rtl/vca_rr_pick.sv
// Rotating-priority pick: search starts one above the last winner.
module vca_rr_pick #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic [IW-1:0] win_idx,
  output logic          win_vld
);
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    for (int k = 1; k <= N; k++) begin
      if (!win_vld && req[(int'(last) + k) % N]) begin
        win_vld = 1'b1;
        win_idx = IW'((int'(last) + k) % N);
      end
    end
  end
endmodule

// File: rtl/vca_free_pick.sv
// Lowest-numbered idle output channel.
module vca_free_pick #(
  parameter int N = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  busy,
  output logic [IW-1:0] free_idx,
  output logic          free_vld
);
  always_comb begin
    free_vld = 1'b0;
    free_idx = '0;
    for (int v = 0; v < N; v++) begin
      if (!free_vld && !busy[v]) begin
        free_vld = 1'b1;
        free_idx = IW'(v);
      end
    end
  end
endmodule

// File: rtl/vca_ovc_slot.sv
// One output channel's occupancy flag and source index.
module vca_ovc_slot #(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [IW-1:0] load_idx,
  input  logic          tail_done,
  output logic          busy,
  output logic [IW-1:0] src_idx
);
  logic          busy_d;
  logic [IW-1:0] src_d;
  logic          en;

  always_comb begin
    busy_d = busy;
    src_d  = src_idx;
    en     = 1'b0;
    if (load) begin
      en     = 1'b1;
      busy_d = 1'b1;
      src_d  = load_idx;
    end else if (tail_done && busy) begin
      en     = 1'b1;
      busy_d = 1'b0;
      src_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      src_idx <= '0;
    end else if (en) begin
      busy    <= busy_d;
      src_idx <= src_d;
    end
  end
endmodule

// File: rtl/vc_admit_ctrl.sv
module vc_admit_ctrl
  import vca_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int NUM_OVC = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_REQ-1:0]                 hdr_req,
  input  logic [NUM_OVC-1:0]                 tail_done,
  output logic [NUM_REQ-1:0]                 hdr_gnt,
  output logic [$clog2(NUM_OVC)-1:0]         gnt_ovc,
  output logic [NUM_OVC-1:0]                 ovc_load,
  output logic [NUM_OVC-1:0]                 ovc_busy,
  output logic [NUM_OVC*$clog2(NUM_REQ)-1:0] ovc_src_idx
);
  localparam int RW = $clog2(NUM_REQ);
  localparam int VW = $clog2(NUM_OVC);

  adm_state_e    state_q, state_d;
  logic [RW-1:0] gnt_idx_q, gnt_idx_d;
  logic [RW-1:0] last_q, last_d;
  logic [VW-1:0] gnt_ovc_d;
  logic [NUM_OVC-1:0] load_d;
  logic [RW-1:0] win_idx;
  logic          win_vld;
  logic [VW-1:0] free_idx;
  logic          free_vld;
  logic          decide;

  vca_rr_pick #(.N(NUM_REQ)) i_rr (
    .req     (hdr_req),
    .last    (last_q),
    .win_idx (win_idx),
    .win_vld (win_vld)
  );

  vca_free_pick #(.N(NUM_OVC)) i_free (
    .busy     (ovc_busy),
    .free_idx (free_idx),
    .free_vld (free_vld)
  );

  assign decide = (state_q == ST_IDLE) && win_vld && free_vld;

  always_comb begin
    state_d   = state_q;
    gnt_idx_d = gnt_idx_q;
    last_d    = last_q;
    gnt_ovc_d = gnt_ovc;
    load_d    = '0;
    case (state_q)
      ST_IDLE: begin
        if (decide) begin
          state_d   = ST_HOLD;
          gnt_idx_d = win_idx;
          last_d    = win_idx;
          gnt_ovc_d = free_idx;
          for (int v = 0; v < NUM_OVC; v++) begin
            load_d[v] = (free_idx == VW'(v));
          end
        end
      end
      default: begin
        if (!hdr_req[gnt_idx_q]) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      gnt_idx_q <= '0;
      last_q    <= RW'(NUM_REQ - 1);
      gnt_ovc   <= '0;
      ovc_load  <= '0;
    end else begin
      state_q  <= state_d;
      ovc_load <= load_d;
      if (decide) begin
        gnt_idx_q <= gnt_idx_d;
        last_q    <= last_d;
        gnt_ovc   <= gnt_ovc_d;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_REQ; i++) begin
      hdr_gnt[i] = (state_q == ST_HOLD) && (gnt_idx_q == RW'(i));
    end
  end

  for (genvar v = 0; v < NUM_OVC; v++) begin : g_slot
    vca_ovc_slot #(.IW(RW)) i_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_d[v]),
      .load_idx  (win_idx),
      .tail_done (tail_done[v]),
      .busy      (ovc_busy[v]),
      .src_idx   (ovc_src_idx[v*RW +: RW])
    );
  end
endmodule

// File: rtl/vca_checker.sv
module vca_checker #(
  parameter int NUM_REQ = 4,
  parameter int NUM_OVC = 2
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [NUM_REQ-1:0]                 hdr_req,
  input logic [NUM_OVC-1:0]                 tail_done,
  input logic [NUM_REQ-1:0]                 hdr_gnt,
  input logic [NUM_OVC-1:0]                 ovc_load,
  input logic [NUM_OVC-1:0]                 ovc_busy
);
  // R2: never more than one grant
  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hdr_gnt));

  // R3: a load never targets a channel that was busy when the choice was made
  a_r3_no_busy_reuse: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovc_load) |-> ((ovc_load & $past(ovc_busy)) == '0));

  // R3: a load needs a pending request in the deciding cycle
  a_r3_load_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovc_load) |-> $past(|hdr_req));

  // R4: a single channel loaded at a time
  a_r4_one_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ovc_load));

  // R5: loaded channel is busy and a grant is shown
  a_r5_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovc_load) |-> (((ovc_load & ~ovc_busy) == '0) && (|hdr_gnt)));

  // R6: grant held while its request stays up
  a_r6_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hdr_gnt) && ((hdr_gnt & hdr_req) != '0)) |=> $stable(hdr_gnt));

  // R7: tail on a busy channel frees it
  a_r7_tail_frees: assert property (@(posedge clk) disable iff (!rst_n)
    ((tail_done & ovc_busy) != '0) |=> ((ovc_busy & $past(tail_done & ovc_busy)) == '0));
endmodule

bind vc_admit_ctrl vca_checker #(.NUM_REQ(NUM_REQ), .NUM_OVC(NUM_OVC)) i_vca_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .hdr_req   (hdr_req),
  .tail_done (tail_done),
  .hdr_gnt   (hdr_gnt),
  .ovc_load  (ovc_load),
  .ovc_busy  (ovc_busy)
);

// File: tb/test_vc_admit_ctrl.sv
module test_vc_admit_ctrl;
  localparam int NUM_REQ = 4;
  localparam int NUM_OVC = 2;

  logic       clk;
  logic       rst_n;
  logic [3:0] hdr_req;
  logic [1:0] tail_done;
  logic [3:0] hdr_gnt;
  logic [0:0] gnt_ovc;
  logic [1:0] ovc_load;
  logic [1:0] ovc_busy;
  logic [3:0] ovc_src_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  vc_admit_ctrl #(.NUM_REQ(NUM_REQ), .NUM_OVC(NUM_OVC)) i_vc_admit_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .hdr_req     (hdr_req),
    .tail_done   (tail_done),
    .hdr_gnt     (hdr_gnt),
    .gnt_ovc     (gnt_ovc),
    .ovc_load    (ovc_load),
    .ovc_busy    (ovc_busy),
    .ovc_src_idx (ovc_src_idx)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_all(input string tag, input int g, input int v, input int ld,
                         input int b, input int s);
    chk({tag, " gnt"},  int'(hdr_gnt), g);
    chk({tag, " ovc"},  int'(gnt_ovc), v);
    chk({tag, " load"}, int'(ovc_load), ld);
    chk({tag, " busy"}, int'(ovc_busy), b);
    chk({tag, " src"},  int'(ovc_src_idx), s);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; hdr_req = '0; tail_done = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset gnt", int'(hdr_gnt), 0);
    chk("R1 in reset busy", int'(ovc_busy), 0);
    rst_n = 1'b1;
    step();
    chk_all("R1 after release", 0, 0, 0, 0, 0);
  endtask

  task automatic t_single();
    hdr_req = 4'b0100;
    step();
    chk_all("R8 R4 R5 single grant", 4'b0100, 0, 2'b01, 2'b01, 4'b0010);
    step();
    chk("R4 load pulse ends", int'(ovc_load), 0);
    chk("R6 grant held", int'(hdr_gnt), 4'b0100);
    hdr_req = 4'b0000;
    step();
    chk("R6 grant released", int'(hdr_gnt), 0);
    chk("R7 busy until tail", int'(ovc_busy), 2'b01);
    tail_done = 2'b01;
    step();
    tail_done = 2'b00;
    chk("R7 tail clears busy", int'(ovc_busy), 0);
    chk("R7 tail zeroes idx", int'(ovc_src_idx), 0);
  endtask

  task automatic t_rr_stall();
    hdr_req = 4'b1111;
    step();
    chk_all("R2 rr after 2 picks 3", 4'b1000, 0, 2'b01, 2'b01, 4'b0011);
    step();
    chk("R6 held with all requesting", int'(hdr_gnt), 4'b1000);
    hdr_req = 4'b0111;
    step();
    chk("R6 release cycle no grant", int'(hdr_gnt), 0);
    step();
    chk_all("R2 R4 wrap to 0 on ovc1", 4'b0001, 1, 2'b10, 2'b11, 4'b0011);
    hdr_req = 4'b0110;
    step();
    chk("R6 release", int'(hdr_gnt), 0);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R3 stall while full", int'(hdr_gnt), 0);
      chk("R3 no load while full", int'(ovc_load), 0);
    end
    tail_done = 2'b10;
    step();
    tail_done = 2'b00;
    chk("R7 ovc1 freed", int'(ovc_busy), 2'b01);
    chk("R3 no grant in free cycle", int'(hdr_gnt), 0);
    step();
    chk_all("R2 R3 next after 0 is 1", 4'b0010, 1, 2'b10, 2'b11, 4'b0111);
  endtask

  task automatic t_lowest();
    tail_done = 2'b01;
    step();
    tail_done = 2'b00;
    chk("R7 ovc0 freed", int'(ovc_busy), 2'b10);
    chk("R7 ovc0 idx zero", int'(ovc_src_idx), 4'b0100);
    chk("R6 still held by req1", int'(hdr_gnt), 4'b0010);
    hdr_req = 4'b0100;
    step();
    chk("R6 release req1", int'(hdr_gnt), 0);
    step();
    chk_all("R4 lowest free is 0", 4'b0100, 0, 2'b01, 2'b11, 4'b0110);
  endtask

  task automatic t_ignore();
    hdr_req = 4'b0000;
    step();
    chk("R6 release req2", int'(hdr_gnt), 0);
    tail_done = 2'b01;
    step();
    tail_done = 2'b00;
    chk("R7 ovc0 freed again", int'(ovc_busy), 2'b10);
    tail_done = 2'b01;
    step();
    tail_done = 2'b00;
    chk("R7 tail on idle ignored busy", int'(ovc_busy), 2'b10);
    chk("R7 tail on idle ignored idx", int'(ovc_src_idx), 4'b0100);
    tail_done = 2'b10;
    step();
    tail_done = 2'b00;
    chk_all("R7 all idle", 0, 0, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_rr_stall();
    t_lowest();
    t_ignore();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule